// File: doc/BRIEF.md
# I2C Master Stop Sequencer with Bus-Collision Detection

This block produces the Stop condition for the master side of an I2C controller and watches for another master on a shared bus while it does so. A one-cycle request starts the sequence. The block holds SDA low, lets SCL float once it has seen SDA low, and waits for SCL to actually read high before it times a baud period. It then lets SDA float, waits one more baud period and reads SDA back.

The two lines are open-drain. The block only pulls a line low through an output-enable and reads both pins through a two-flop synchronizer. Each baud period comes from a down-counter loaded with a 7-bit reload value, and a reload of zero acts as one. A clean Stop raises a completion flag and a stop-seen status bit. A collision raises a collision flag, drops the busy indication and lets go of both lines. The two flags stay set until their clear inputs are pulsed.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, sda_oe, scl_oe, stop_en, done_irq, coll_irq and stop_seen are all 0 (an oe value of 1 means the line is pulled low).
- R2: A stop_req pulse while stop_en is 0 sets stop_en and pulls both SDA and SCL low on the next cycle, and clears stop_seen. A stop_req while stop_en is 1 has no effect.
- R3: SCL is released only after synchronized SDA reads low. With a free bus, the SDA-low-only phase lasts 3 cycles.
- R4: After SCL is released, timing starts only once synchronized SCL reads high. The cycles with SCL released and SDA still held equal eff+3 on a free bus, or eff+3+k when another device stretches SCL for k cycles, where eff is the reload value, or 1 if the reload is 0. Stretching is not a collision.
- R5: After the SCL-high period, SDA is released. Synchronized SDA is checked on the last of eff+2 cycles with SDA released (2 cycles allow for the synchronizer).
- R6: If that check reads SDA high, done_irq and stop_seen are set, stop_en clears, and both lines are released in the same edge.
- R7: If that check reads SDA low, coll_irq is set instead of done_irq, stop_seen stays 0, stop_en clears and both lines are released.
- R8: If synchronized SCL reads low during the SCL-high period, before SDA is released, coll_irq is set, the sequence aborts without ever releasing SDA during the sequence, and both lines are released.
- R9: A reload of 0 behaves as a reload of 1.
- R10: done_irq and coll_irq remain set until clr_done or clr_coll is high. A clear in the same cycle as a set wins, so the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_req | input | 1 | One-cycle request to start a Stop |
| reload | input | RELOAD_W | Baud-period reload value |
| sda_in | input | 1 | SDA pin level |
| scl_in | input | 1 | SCL pin level |
| clr_done | input | 1 | Clears done_irq |
| clr_coll | input | 1 | Clears coll_irq |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| stop_en | output | 1 | Sequence in progress |
| done_irq | output | 1 | Sticky completion flag |
| coll_irq | output | 1 | Sticky bus-collision flag |
| stop_seen | output | 1 | Last Stop finished cleanly |

## Verification
The bench models the bus as the wired-AND of the block and a second driver. It runs both collision cases. When SDA is pulled low after release, a design that skips the read-back would report success. When SCL is pulled low while it should be high, a design that ignores it would go on to release SDA, and the bench counts that as released SDA cycles. A bench-driven SCL stretch catches a design that starts timing on release instead of on the observed high level, or that mistakes stretching for a collision. A reload of 0 catches a counter that wraps instead of lasting one cycle. A clear timed to the exact set cycle catches a design that gives set priority over clear.

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq #(
  parameter int RELOAD_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_req,
  input  logic [RELOAD_W-1:0] reload,
  input  logic                sda_in,
  input  logic                scl_in,
  input  logic                clr_done,
  input  logic                clr_coll,
  output logic                sda_oe,
  output logic                scl_oe,
  output logic                stop_en,
  output logic                done_irq,
  output logic                coll_irq,
  output logic                stop_seen
);
  localparam int CW       = RELOAD_W + 1;
  localparam int SYNC_LAT = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SDA_LO, ST_SCL_REL, ST_SCL_HI, ST_SDA_HI
  } state_t;

  state_t        state;
  logic [1:0]    sda_sync, scl_sync;
  logic          sda_s, scl_s;
  logic [CW-1:0] cnt, eff;
  logic          set_done, set_coll;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sda_sync <= 2'b11;
      scl_sync <= 2'b11;
    end else begin
      sda_sync <= {sda_sync[0], sda_in};
      scl_sync <= {scl_sync[0], scl_in};
    end

  assign sda_s = sda_sync[1];
  assign scl_s = scl_sync[1];
  assign eff   = (reload == '0) ? CW'(1) : {1'b0, reload};

  assign sda_oe  = (state == ST_SDA_LO) || (state == ST_SCL_REL) || (state == ST_SCL_HI);
  assign scl_oe  = (state == ST_SDA_LO);
  assign stop_en = (state != ST_IDLE);

  assign set_done = (state == ST_SDA_HI) && (cnt == CW'(1)) && sda_s;
  assign set_coll = ((state == ST_SDA_HI) && (cnt == CW'(1)) && !sda_s) ||
                    ((state == ST_SCL_HI) && !scl_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:    if (stop_req) state <= ST_SDA_LO;
        ST_SDA_LO:  if (!sda_s) state <= ST_SCL_REL;
        ST_SCL_REL: if (scl_s) begin
                      state <= ST_SCL_HI;
                      cnt   <= eff;
                    end
        ST_SCL_HI:  if (!scl_s) state <= ST_IDLE;
                    else if (cnt == CW'(1)) begin
                      state <= ST_SDA_HI;
                      cnt   <= eff + CW'(SYNC_LAT);
                    end else cnt <= cnt - CW'(1);
        ST_SDA_HI:  if (cnt == CW'(1)) state <= ST_IDLE;
                    else cnt <= cnt - CW'(1);
        default:    state <= ST_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_irq  <= 1'b0;
      coll_irq  <= 1'b0;
      stop_seen <= 1'b0;
    end else begin
      if (clr_done)      done_irq <= 1'b0;
      else if (set_done) done_irq <= 1'b1;
      if (clr_coll)      coll_irq <= 1'b0;
      else if (set_coll) coll_irq <= 1'b1;
      if (state == ST_IDLE && stop_req) stop_seen <= 1'b0;
      else if (set_done)                stop_seen <= 1'b1;
    end

  a_r2_req_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !stop_en) |=> (stop_en && sda_oe && scl_oe && !stop_seen));
  a_r3_scl_after_sda_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> !$past(sda_s));
  a_r4_sda_rel_after_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_oe) && stop_en) |-> (!scl_oe && $past(scl_s)));
  a_r6_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_en |-> (!sda_oe && !scl_oe));
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(done_irq) && $rose(coll_irq)));
  a_r8_coll_ends_seq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_irq) |-> !stop_en);
  a_r10_clear_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !done_irq);
  a_r10_clear_coll_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_coll |=> !coll_irq);
endmodule

// File: tb/sim_i2c_stop_seq.sv
module sim_i2c_stop_seq;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       stop_req = 0;
  logic [6:0] reload = 7'd5;
  logic       clr_done = 0, clr_coll = 0;
  logic       other_sda = 1, other_scl = 1;
  logic       sda_oe, scl_oe, stop_en, done_irq, coll_irq, stop_seen;
  logic       sda_bus, scl_bus;

  int checks = 0, failures = 0;

  assign sda_bus = ~sda_oe & other_sda;
  assign scl_bus = ~scl_oe & other_scl;

  always #10 clk = ~clk;

  i2c_stop_seq #(.RELOAD_W(7)) u0 (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .reload(reload),
    .sda_in(sda_bus), .scl_in(scl_bus), .clr_done(clr_done), .clr_coll(clr_coll),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .stop_en(stop_en),
    .done_irq(done_irq), .coll_irq(coll_irq), .stop_seen(stop_seen));

  typedef struct {
    string tag;
    bit    coll, done, seen, chk_scl;
    int    sda_cyc, scl_cyc, lo_cyc;
  } exp_t;

  exp_t q[$];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int  n_sda = 0, n_scl = 0, n_lo = 0;
  bit  was_busy = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (stop_en && !sda_oe) n_sda++;
      if (stop_en && !scl_oe && sda_oe) n_scl++;
      if (stop_en && scl_oe) n_lo++;
      if (was_busy && !stop_en) begin
        if (q.size() == 0) check("R2 unexpected completion", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " coll_irq"}, coll_irq, e.coll);
          check({e.tag, " done_irq"}, done_irq, e.done);
          check({e.tag, " stop_seen"}, stop_seen, e.seen);
          check({e.tag, " sda released cycles"}, n_sda, e.sda_cyc);
          if (e.chk_scl) check({e.tag, " scl high cycles"}, n_scl, e.scl_cyc);
          check({e.tag, " R3 sda-low phase cycles"}, n_lo, e.lo_cyc);
          check({e.tag, " lines released"}, {sda_oe, scl_oe}, 0);
        end
        n_sda = 0; n_scl = 0; n_lo = 0;
      end
      was_busy = stop_en;
    end
  end

  task automatic clear_flags();
    @(negedge clk); clr_done = 1; clr_coll = 1;
    @(negedge clk); clr_done = 0; clr_coll = 0;
  endtask

  // mode: 0 normal, 1 SCL stretch by k, 2 SDA collision, 3 SCL collision, 4 clear on set
  task automatic run_stop(input string tag, input int rl, input int mode, input int k);
    exp_t e;
    int eff;
    eff = (rl == 0) ? 1 : rl;
    e.tag = tag; e.coll = (mode == 2 || mode == 3); e.done = (mode == 0 || mode == 1);
    e.seen = (mode != 2 && mode != 3);
    e.sda_cyc = (mode == 3) ? 0 : eff + 2;
    e.chk_scl = (mode != 3);
    e.scl_cyc = eff + 3 + ((mode == 1) ? k : 0);
    e.lo_cyc = 3;
    q.push_back(e);
    reload = 7'(rl);
    if (mode == 1) other_scl = 0;
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    if (mode == 0) begin
      stop_req = 1;
      @(negedge clk); stop_req = 0;
    end
    while (!(stop_en && !scl_oe)) @(negedge clk);
    case (mode)
      1: begin repeat (k) @(negedge clk); other_scl = 1; end
      3: begin repeat (4) @(negedge clk); other_scl = 0; end
      2: begin while (!(stop_en && !sda_oe)) @(negedge clk); other_sda = 0; end
      4: begin
           while (!(stop_en && !sda_oe)) @(negedge clk);
           repeat (eff + 1) @(negedge clk);
           clr_done = 1;
           @(negedge clk); clr_done = 0;
         end
      default: ;
    endcase
    while (stop_en) @(negedge clk);
    @(negedge clk);
    other_sda = 1; other_scl = 1;
    check({tag, " R2 stays idle"}, stop_en, 0);
    repeat (3) @(negedge clk);
    clear_flags();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset oe", {sda_oe, scl_oe}, 0);
    check("R1 reset flags", {stop_en, done_irq, coll_irq, stop_seen}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_stop("R6 R5 normal reload5", 5, 0, 0);
    run_stop("R9 reload0", 0, 0, 0);
    run_stop("R6 reload1", 1, 0, 0);
    run_stop("R4 stretch", 6, 1, 7);
    run_stop("R7 sda collision", 8, 2, 0);
    run_stop("R8 scl collision", 20, 3, 0);
    run_stop("R10 clear beats set", 4, 4, 0);
    run_stop("R6 reload127", 127, 0, 0);
    @(negedge clk);
    check("R10 flags cleared", {done_irq, coll_irq}, 0);
    check("R2 queue drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule